// File: doc/BRIEF.md
# Time-Slotted Routing Switch Enable Store

This block keeps the routing pattern of one processing node in a spiking fabric. Before the node starts, a host loads one configuration word per time slot of the multiplex cycle. While the node is running, the cycle sequencer presents a slot index together with a slot-start strobe. The block then looks up that slot's word and drives one enable line for each routing buffer in the node. The enables are held until the next slot starts, so the same pattern comes back in every multiplex cycle.

Some pairs of buffers form a bidirectional switch, and at most one direction of such a switch may conduct. The block checks every word as it is applied. When a pair has both bits set, the block turns both enables of that pair off and latches a sticky error flag. All other bits pass through unchanged. Every node uses the same hardware; only the loaded contents differ.

Top module: `route_slot_store`

## Requirements
- R1: After reset all enable outputs are 0 and the error flag is low; every stored row reads as 0.
- R2: While `run` is low, a cycle with `ldWe` high and `ldAddr` below NUM_SLOTS (default 32) stores `ldData` as the row for slot `ldAddr`.
- R3: A load cycle while `run` is high stores nothing.
- R4: A load to an address of NUM_SLOTS or more stores nothing.
- R5: On a clock edge with `run` and `slotStart` high and `slotIdx` below NUM_SLOTS, `swEn` takes the filtered row of `slotIdx` one cycle later. It holds that value while `slotStart` stays low.
- R6: Stepping through slots 0 to NUM_SLOTS-1 and wrapping back to slot 0 reproduces the same enables in every cycle.
- R7: Bits 2k and 2k+1 for k = 0..NUM_PAIRS-1 (default 8, so bits 0..15) are the two directions of one bidirectional switch. If both are set in a row, both outputs are driven 0. Every other bit equals the stored bit.
- R8: `pairErr` rises on the edge that applies a row with a conflicting pair. It stays high until reset.
- R9: A slot start with `slotIdx` of NUM_SLOTS or more drives all enables to 0.
- R10: When `run` is low at a clock edge, all enables are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | High while the node operates; low allows loading |
| ldWe | input | 1 | Load write enable |
| ldAddr | input | 7 | Slot row to load |
| ldData | input | 34 | Configuration word |
| slotStart | input | 1 | Strobe marking the first cycle of a slot |
| slotIdx | input | 7 | Current slot number from the sequencer |
| swEn | output | 34 | Registered buffer enables |
| pairErr | output | 1 | Sticky bidirectional conflict flag |

## Verification
A corrupted row shows up as a wrong enable one cycle after its slot starts. Because the pattern repeats, the same wrong enable appears again on every later visit to that slot. A load that is wrongly accepted during run, or that aliases an out-of-range address, is caught on the next visit to the aliased row. A broken pair filter shows at once, either as two conducting directions or as a missing error flag in the cycle after the conflicting slot.

// File: rtl/route_slot_pkg.sv
package route_slot_pkg;
  typedef struct packed {
    logic wrRow;    // store the load word
    logic loadOut;  // apply the addressed row to the enables
    logic clrOut;   // drive every enable low
  } slot_strobe_t;
endpackage

// File: rtl/route_slot_ctrl.sv
module route_slot_ctrl
  import route_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = 7
) (
  input  logic              run,
  input  logic              ldWe,
  input  logic [SLOT_W-1:0] ldAddr,
  input  logic              slotStart,
  input  logic [SLOT_W-1:0] slotIdx,
  output slot_strobe_t      stb
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic addrOk;
  logic slotOk;

  always_comb begin
    addrOk      = (ldAddr <= LAST_SLOT);
    slotOk      = (slotIdx <= LAST_SLOT);
    stb.wrRow   = ldWe & ~run & addrOk;
    stb.loadOut = run & slotStart & slotOk;
    stb.clrOut  = ~run | (slotStart & ~slotOk);
  end
endmodule

// File: rtl/route_slot_dp.sv
module route_slot_dp
  import route_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = 7,
  parameter int SW_BITS   = 34,
  parameter int NUM_PAIRS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  slot_strobe_t       stb,
  input  logic [SLOT_W-1:0]  ldAddr,
  input  logic [SW_BITS-1:0] ldData,
  input  logic [SLOT_W-1:0]  slotIdx,
  output logic [SW_BITS-1:0] swEn,
  output logic               pairErr
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int PAIR_BITS = 2 * NUM_PAIRS;

  logic [SW_BITS-1:0]   rowMem [NUM_SLOTS];
  logic [SW_BITS-1:0]   rowData;
  logic [SW_BITS-1:0]   cleanRow;
  logic [NUM_PAIRS-1:0] pairHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) rowMem[i] <= '0;
    end else if (stb.wrRow) begin
      rowMem[ldAddr[IDX_W-1:0]] <= ldData;
    end
  end

  assign rowData = rowMem[slotIdx[IDX_W-1:0]];

  for (genvar k = 0; k < SW_BITS; k++) begin : g_bit
    if (k < PAIR_BITS) begin : g_paired
      localparam int MATE = k ^ 1;
      assign cleanRow[k] = rowData[k] & ~rowData[MATE];
    end else begin : g_single
      assign cleanRow[k] = rowData[k];
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pairHit[p] = rowData[2*p] & rowData[2*p+1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swEn    <= '0;
      pairErr <= 1'b0;
    end else begin
      if (stb.clrOut)       swEn <= '0;
      else if (stb.loadOut) swEn <= cleanRow;
      if (stb.loadOut && |pairHit) pairErr <= 1'b1;
    end
  end
endmodule

// File: rtl/route_slot_store.sv
module route_slot_store
  import route_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W    = 7,
  parameter int SW_BITS   = 34,
  parameter int NUM_PAIRS = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic               ldWe,
  input  logic [SLOT_W-1:0]  ldAddr,
  input  logic [SW_BITS-1:0] ldData,
  input  logic               slotStart,
  input  logic [SLOT_W-1:0]  slotIdx,
  output logic [SW_BITS-1:0] swEn,
  output logic               pairErr
);
  slot_strobe_t stb;

  route_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .run(run), .ldWe(ldWe), .ldAddr(ldAddr),
    .slotStart(slotStart), .slotIdx(slotIdx), .stb(stb)
  );

  route_slot_dp #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W),
    .SW_BITS(SW_BITS), .NUM_PAIRS(NUM_PAIRS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ldAddr(ldAddr), .ldData(ldData),
    .slotIdx(slotIdx), .swEn(swEn), .pairErr(pairErr)
  );
endmodule

// File: rtl/route_slot_store_chk.sv
module route_slot_store_chk #(
  parameter int SW_BITS   = 34,
  parameter int NUM_PAIRS = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               run,
  input logic               slotStart,
  input logic [SW_BITS-1:0] swEn,
  input logic               pairErr
);
  logic bothOn;

  always_comb begin
    bothOn = 1'b0;
    for (int p = 0; p < NUM_PAIRS; p++) bothOn |= swEn[2*p] & swEn[2*p+1];
  end

  // R7
  pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN) !bothOn);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN) pairErr |=> pairErr);

  // R10
  idle_off_chk: assert property (@(posedge clk) disable iff (!rstN) !run |=> (swEn == '0));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (run && !slotStart) |=> $stable(swEn));
endmodule

bind route_slot_store route_slot_store_chk #(.SW_BITS(SW_BITS), .NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk(clk), .rstN(rstN), .run(run), .slotStart(slotStart),
  .swEn(swEn), .pairErr(pairErr)
);

// File: tb/route_slot_store_test.sv
module route_slot_store_test;
  localparam int N  = 32;
  localparam int SW = 34;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          run;
  logic          ldWe;
  logic [6:0]    ldAddr;
  logic [SW-1:0] ldData;
  logic          slotStart;
  logic [6:0]    slotIdx;
  logic [SW-1:0] swEn;
  logic          pairErr;

  int testCnt = 0;
  int failCnt = 0;
  logic [SW-1:0] model [N];
  logic modelErr = 1'b0;

  always #4 clk = ~clk;

  route_slot_store uut (
    .clk(clk), .rstN(rstN), .run(run), .ldWe(ldWe), .ldAddr(ldAddr),
    .ldData(ldData), .slotStart(slotStart), .slotIdx(slotIdx),
    .swEn(swEn), .pairErr(pairErr)
  );

  function automatic logic [SW-1:0] filterRow(logic [SW-1:0] r);
    logic [SW-1:0] o = r;
    for (int p = 0; p < NP; p++)
      if (r[2*p] && r[2*p+1]) begin o[2*p] = 1'b0; o[2*p+1] = 1'b0; end
    return o;
  endfunction

  function automatic logic hasClash(logic [SW-1:0] r);
    for (int p = 0; p < NP; p++) if (r[2*p] && r[2*p+1]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [SW-1:0] randRow(bit clean);
    logic [SW-1:0] r = SW'({$urandom(), $urandom()});
    if (clean) for (int p = 0; p < NP; p++) if (r[2*p] && r[2*p+1]) r[2*p+1] = 1'b0;
    return r;
  endfunction

  task automatic check(string req, logic [SW-1:0] act, logic [SW-1:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadRow(int addr, logic [SW-1:0] d);
    ldWe = 1'b1; ldAddr = 7'(addr); ldData = d;
    @(posedge clk);
    @(negedge clk);
    ldWe = 1'b0;
    if (!run && addr < N) model[addr] = d;
  endtask

  // start a slot and check the enables one cycle later
  task automatic visit(int idx, string req);
    logic [SW-1:0] exp;
    slotStart = 1'b1; slotIdx = 7'(idx);
    @(posedge clk);
    @(negedge clk);
    slotStart = 1'b0;
    exp = (idx < N) ? filterRow(model[idx]) : '0;
    if (idx < N && hasClash(model[idx])) modelErr = 1'b1;
    check(req, swEn, exp);
    check({req, " err"}, {{(SW-1){1'b0}}, pairErr}, {{(SW-1){1'b0}}, modelErr});
  endtask

  initial begin
    #(8 * 150000);
    failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    rstN = 1'b0; run = 1'b0; ldWe = 1'b0; ldAddr = '0; ldData = '0;
    slotStart = 1'b0; slotIdx = '0;
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check("R1 enables", swEn, '0);
    check("R1 err", {{(SW-1){1'b0}}, pairErr}, '0);
    run = 1'b1;
    visit(5, "R1 row cleared");

    // R2: load clean random rows
    run = 1'b0;
    @(negedge clk);
    check("R10 idle", swEn, '0);
    for (int i = 0; i < N; i++) loadRow(i, randRow(1'b1));
    // R4: out-of-range address must not alias onto row 8
    loadRow(N + 8, '1);
    run = 1'b1;
    // R5/R6: two full cycles, with hold cycles between starts
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < N; i++) begin
        visit(i, (c == 0) ? "R5 slot" : "R6 repeat");
        if (i % 5 == 0) begin
          @(negedge clk);
          check("R5 hold", swEn, filterRow(model[i]));
        end
      end
    visit(8, "R4 alias");
    // R3: load during run is ignored
    loadRow(3, ~model[3]);
    visit(3, "R3 run write");
    // R9: out-of-range slot
    visit(N + 2, "R9 range");
    visit(2, "R5 after range");

    // R7/R8: conflicting pair plus directed row
    run = 1'b0;
    @(negedge clk);
    loadRow(4, 34'h3_0000_0003);
    loadRow(6, 34'h0_0000_8001);
    run = 1'b1;
    visit(6, "R7 clean pair");
    visit(4, "R7 clash");
    check("R7 upper bits", swEn, 34'h3_0000_0000);
    visit(6, "R8 sticky");
    // random mixed rows including conflicts
    run = 1'b0;
    @(negedge clk);
    for (int i = 0; i < N; i++) loadRow(i, randRow(1'b0));
    run = 1'b1;
    for (int i = 0; i < N; i++) visit(int'($urandom_range(N - 1)), "R7 random");
    run = 1'b0;
    @(negedge clk);
    check("R10 stop", swEn, '0);
    // R1: reset clears sticky flag
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 err clear", {{(SW-1){1'b0}}, pairErr}, '0);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule